// File: doc/BRIEF.md
# Burst-Capable Long-Word Write Target

This block is a synchronous memory target that sits below a bus master and accepts write transfers into a small array of 32-bit words. A transfer starts with a one-cycle start strobe. In that same cycle the master presents the direction, the size code and the word-aligned address. From the next cycle on, the master holds the write data on the data bus until the target acknowledges. The target inserts a configurable number of wait states before each acknowledge. It stores the data word in the cycle that carries the acknowledge.

A line transfer moves four long words. The master keeps the address constant for the whole line, so the target keeps its own copy of the long-word offset within the 16-byte line. It steps that offset after every beat and wraps it inside the line. A configuration input decides whether the target takes the whole line as a burst. If it refuses, it raises the burst-refusal output together with the first acknowledge and ends the transfer after one word. The master then sends the remaining words as separate long-word transfers, each with its own address. A combinational read-back port lets a test environment inspect any stored word.

Top module: `burst_write_slave`

## Requirements
- R1: After reset, `ack_o` and `burst_inh_o` are low and every stored word reads back as zero.
- R2: A start is taken only while no transfer is in progress, with `rnw_i`=0 and `size_i` equal to 2'b00 (long word) or 2'b11 (line). A start with `rnw_i`=1, or with `size_i` equal to 2'b01 or 2'b10, is ignored: it produces no acknowledge and changes no stored word.
- R3: With `wait_cfg_i`=N (0 to 3) sampled in the start cycle, the acknowledge for beat k (k counted from 0) is high in cycle (k+1)*(N+1), where the start cycle is cycle 0. Each acknowledge lasts exactly one cycle.
- R4: The value on `data_i` in an acknowledge cycle is stored at that beat's word index.
- R5: A long-word write has one beat and stores at word index `waddr_i`. `burst_inh_o` stays low throughout.
- R6: A line write with `burst_en_i`=1 has four beats and `burst_inh_o` stays low. Beat k stores at word index {`waddr_i`[AW-1:4], (`waddr_i`[3:2]+k) mod 4}.
- R7: A line write with `burst_en_i`=0 has one beat and stores only at word index `waddr_i`. `burst_inh_o` is high in that acknowledge cycle and in no other cycle.
- R8: `burst_inh_o` is never high without `ack_o`. After the last beat of a transfer, no acknowledge appears until a new start is accepted.
- R9: `rd_data_o` shows the stored word at index `rd_idx_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transfer start strobe, one cycle |
| rnw_i | input | 1 | 1 = read (ignored), 0 = write |
| size_i | input | 2 | 00 long word, 01 byte, 10 word, 11 line |
| waddr_i | input | AW-2 | Byte address bits AW-1 down to 2 |
| data_i | input | DATA_W | Write data, held by the master until acknowledged |
| burst_en_i | input | 1 | 1 = accept line bursts, 0 = refuse them |
| wait_cfg_i | input | WAIT_W | Wait states inserted before every beat |
| ack_o | output | 1 | Beat acknowledge |
| burst_inh_o | output | 1 | Burst refused, valid only with the first acknowledge |
| rd_idx_i | input | AW-2 | Read-back word index |
| rd_data_o | output | DATA_W | Read-back word |

## Verification
The bench starts a line at a nonzero offset within the line. A target that did not wrap would spill beats into the next line, and one that took its offset from the bus for every beat would write all four beats to the same word. The bench runs every wait setting from zero to three, including back-to-back zero-wait beats. A timer that counts one cycle too many or too few shifts each acknowledge, and the cycle-exact comparison catches that. Refused lines are followed by separate long-word writes, so a target that kept bursting, or raised the refusal signal on a later beat or on a plain long-word write, leaves wrong memory contents or a stray refusal pulse. Reads and sub-long-word sizes are issued as well. A target that acknowledged them would hang no master here, but it would show an acknowledge or an altered word.

// File: rtl/bws_pkg.sv
package bws_pkg;

    // Size codes on the transfer attribute lines
    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LINE = 2'b11
    } size_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BEAT = 1'b1
    } state_e;

    // Long words in one line
    localparam int unsigned LINE_BEATS = 4;
    localparam int unsigned BEAT_W     = $clog2(LINE_BEATS);

endpackage

// File: rtl/bws_decode.sv
module bws_decode
    import bws_pkg::*;
(
    input  logic       idle_i,
    input  logic       start_i,
    input  logic       rnw_i,
    input  logic [1:0] size_i,
    input  logic       burst_en_i,
    output logic       accept_o,
    output logic       is_line_o,
    output logic       burst_o
);

    size_e size_s;

    always_comb begin
        size_s    = size_e'(size_i);
        is_line_o = (size_s == SZ_LINE);
        // Only long-word and line writes are served
        accept_o  = idle_i && start_i && !rnw_i &&
                    ((size_s == SZ_LONG) || (size_s == SZ_LINE));
        burst_o   = is_line_o && burst_en_i;
    end

endmodule

// File: rtl/bws_wait_timer.sv
module bws_wait_timer #(
    parameter int unsigned WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WAIT_W-1:0] cfg_i,
    input  logic              reload_i,
    input  logic              active_i,
    output logic              expire_o
);

    typedef struct packed {
        logic [WAIT_W-1:0] cfg;
        logic [WAIT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cfg = cfg_i;
            tmr_d.cnt = cfg_i;
        end else if (reload_i) begin
            tmr_d.cnt = tmr_q.cfg;
        end else if (active_i && (tmr_q.cnt != '0)) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
        expire_o = active_i && (tmr_q.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R3: a nonzero wait setting delays the first beat past the next cycle
    assert_wait_first_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (cfg_i != '0)) |=> !expire_o);

    // R3: a nonzero wait setting also delays every following beat
    assert_wait_next_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i && (tmr_q.cfg != '0)) |=> !expire_o);

endmodule

// File: rtl/bws_beat_ctr.sv
module bws_beat_ctr
    import bws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BEAT_W-1:0] base_i,
    input  logic              step_i,
    output logic [BEAT_W-1:0] off_o,
    output logic [BEAT_W-1:0] count_o
);

    typedef struct packed {
        logic [BEAT_W-1:0] off;
        logic [BEAT_W-1:0] count;
    } beat_t;

    beat_t beat_d, beat_q;

    always_comb begin
        beat_d = beat_q;
        if (load_i) begin
            beat_d.off   = base_i;
            beat_d.count = '0;
        end else if (step_i) begin
            // Offset wraps inside the line
            beat_d.off   = beat_q.off + 1'b1;
            beat_d.count = beat_q.count + 1'b1;
        end
        off_o   = beat_q.off;
        count_o = beat_q.count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    // R6: each completed non-final beat moves to the next long word, modulo the line
    assert_offset_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (off_o == BEAT_W'($past(off_o) + 1'b1)));

endmodule

// File: rtl/bws_mem.sv
module bws_mem #(
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_i) begin
            mem_d[widx_i] = wdata_i;
        end
        rdata_o = mem_q[ridx_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

endmodule

// File: rtl/burst_write_slave.sv
module burst_write_slave
    import bws_pkg::*;
#(
    parameter int unsigned AW     = 6,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rnw_i,
    input  logic [1:0]        size_i,
    input  logic [AW-1:2]     waddr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              burst_en_i,
    input  logic [WAIT_W-1:0] wait_cfg_i,
    output logic              ack_o,
    output logic              burst_inh_o,
    input  logic [AW-1:2]     rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int unsigned IDX_W  = AW - 2;
    localparam int unsigned LINE_W = IDX_W - BEAT_W;

    typedef struct packed {
        state_e            state;
        logic              line;
        logic              burst;
        logic [LINE_W-1:0] hi;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              accept_s, is_line_s, burst_s;
    logic              expire_s, last_s, step_s;
    logic [BEAT_W-1:0] off_s, count_s;
    logic [IDX_W-1:0]  widx_s;

    bws_decode u_decode (
        .idle_i     (ctl_q.state == ST_IDLE),
        .start_i    (start_i),
        .rnw_i      (rnw_i),
        .size_i     (size_i),
        .burst_en_i (burst_en_i),
        .accept_o   (accept_s),
        .is_line_o  (is_line_s),
        .burst_o    (burst_s)
    );

    bws_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept_s),
        .cfg_i    (wait_cfg_i),
        .reload_i (step_s),
        .active_i (ctl_q.state == ST_BEAT),
        .expire_o (expire_s)
    );

    bws_beat_ctr u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept_s),
        .base_i  (waddr_i[BEAT_W+1:2]),
        .step_i  (step_s),
        .off_o   (off_s),
        .count_o (count_s)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ack_o       = expire_s;
        last_s      = !(ctl_q.line && ctl_q.burst) ||
                      (count_s == BEAT_W'(LINE_BEATS - 1));
        step_s      = ack_o && !last_s;
        // Refusal is reported only with the first beat of a line
        burst_inh_o = ack_o && ctl_q.line && !ctl_q.burst && (count_s == '0);
        widx_s      = {ctl_q.hi, off_s};

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (accept_s) begin
                    ctl_d.state = ST_BEAT;
                    ctl_d.line  = is_line_s;
                    ctl_d.burst = burst_s;
                    ctl_d.hi    = waddr_i[AW-1:BEAT_W+2];
                end
            end
            ST_BEAT: begin
                if (ack_o && last_s) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, line: 1'b0, burst: 1'b0, hi: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    bws_mem #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ack_o),
        .widx_i  (widx_s),
        .wdata_i (data_i),
        .ridx_i  (rd_idx_i),
        .rdata_o (rd_data_o)
    );

    // R8: refusal only travels with an acknowledge
    assert_inh_with_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_inh_o |-> ack_o);

    // R8: nothing follows the final beat without a new start
    assert_quiet_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && last_s) |=> !ack_o);

    // R2: an unserved start leaves the target idle
    assert_ignore_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.state == ST_IDLE) && start_i && !accept_s) |=> !ack_o);

    // R7: a refused line ends at its first beat
    assert_refused_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        burst_inh_o |=> (ctl_q.state == ST_IDLE));

endmodule

// File: tb/test_burst_write_slave.sv
`timescale 1ns/1ps
module test_burst_write_slave;

    localparam int AW = 6;
    localparam int DEPTH = 1 << (AW - 2);
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rnw_i = 1'b0;
    logic [1:0]  size_i = 2'b00;
    logic [AW-1:2] waddr_i = '0;
    logic [31:0] data_i = '0;
    logic        burst_en_i = 1'b1;
    logic [1:0]  wait_cfg_i = 2'd0;
    logic        ack_o, burst_inh_o;
    logic [AW-1:2] rd_idx_i = '0;
    logic [31:0] rd_data_o;

    int n_checks = 0;
    int n_fail = 0;
    int seed = 1;
    logic [31:0] model [DEPTH];

    always #(HALF) clk = ~clk;

    burst_write_slave #(.AW(AW)) i_burst_write_slave (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rnw_i(rnw_i),
        .size_i(size_i), .waddr_i(waddr_i), .data_i(data_i),
        .burst_en_i(burst_en_i), .wait_cfg_i(wait_cfg_i), .ack_o(ack_o),
        .burst_inh_o(burst_inh_o), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R9: compare every stored word with the bench model
    task automatic check_mem(input string req);
        for (int i = 0; i < DEPTH; i++) begin
            rd_idx_i = (AW-2)'(i);
            #0.1;
            check(rd_data_o === model[i], req, rd_data_o, model[i]);
        end
    endtask

    // One transfer; beats and refusal expected from the requirements
    task automatic run_xfer(input logic rnw, input logic [1:0] size,
                            input logic [AW-1:2] addr, input int nwait,
                            input logic ben, input int beats, input bit inh,
                            input string req);
        logic [31:0] dat [4];
        int k = 0;
        int limit = (beats + 1) * (nwait + 1) + 3;
        for (int b = 0; b < 4; b++) begin
            dat[b] = 32'h5A00_0000 ^ (seed << 8) ^ b;
        end
        seed++;
        @(negedge clk);
        start_i = 1'b1; rnw_i = rnw; size_i = size; waddr_i = addr;
        burst_en_i = ben; wait_cfg_i = 2'(nwait); data_i = 32'hDEAD_BEEF;
        for (int c = 1; c <= limit; c++) begin
            @(negedge clk);
            start_i = 1'b0;
            data_i = dat[k < 4 ? k : 3];
            if (ack_o) begin
                logic [AW-1:2] wi;
                // R3: beat k acknowledged in cycle (k+1)*(N+1)
                check(c == (k + 1) * (nwait + 1), {req, " R3 ack timing"}, c,
                      (k + 1) * (nwait + 1));
                // R7/R8: refusal only on first beat of a refused line
                check(burst_inh_o == (inh && k == 0), {req, " R7 refusal"},
                      burst_inh_o, (inh && k == 0));
                wi = addr;
                wi[3:2] = 2'(addr[3:2] + k);
                model[wi] = dat[k < 4 ? k : 3];
                k++;
            end else begin
                check(burst_inh_o == 1'b0, {req, " R8 refusal without ack"},
                      burst_inh_o, 0);
            end
        end
        // R8: number of beats; no acknowledge after the last one
        check(k == beats, {req, " R8 beat count"}, k, beats);
        check_mem({req, " R4 stored data"});
    endtask

    task automatic t_reset();
        check(ack_o == 1'b0, "R1 ack after reset", ack_o, 0);
        check(burst_inh_o == 1'b0, "R1 refusal after reset", burst_inh_o, 0);
        check_mem("R1 memory zero after reset");
    endtask

    task automatic t_long();
        for (int n = 0; n < 4; n++) begin
            run_xfer(1'b0, 2'b00, 4'(n * 5 + 1), n, 1'b1, 1, 1'b0, "R5 long write");
        end
        run_xfer(1'b0, 2'b00, 4'd7, 0, 1'b0, 1, 1'b0, "R5 long write, bursts off");
    endtask

    task automatic t_burst();
        run_xfer(1'b0, 2'b11, 4'b0100, 0, 1'b1, 4, 1'b0, "R6 burst aligned");
        run_xfer(1'b0, 2'b11, 4'b1010, 1, 1'b1, 4, 1'b0, "R6 burst wrap offset 2");
        run_xfer(1'b0, 2'b11, 4'b1111, 3, 1'b1, 4, 1'b0, "R6 burst wrap offset 3");
        run_xfer(1'b0, 2'b11, 4'b0001, 2, 1'b1, 4, 1'b0, "R6 burst wrap offset 1");
    endtask

    task automatic t_refused();
        logic [AW-1:2] a = 4'b0110;
        run_xfer(1'b0, 2'b11, a, 1, 1'b0, 1, 1'b1, "R7 refused line");
        for (int j = 1; j < 4; j++) begin
            logic [AW-1:2] b = a;
            b[3:2] = 2'(a[3:2] + j);
            run_xfer(1'b0, 2'b00, b, 1, 1'b0, 1, 1'b0, "R7 follow-up long write");
        end
        run_xfer(1'b0, 2'b11, 4'b1100, 0, 1'b0, 1, 1'b1, "R7 refused line no wait");
    endtask

    task automatic t_ignored();
        run_xfer(1'b1, 2'b00, 4'd2, 0, 1'b1, 0, 1'b0, "R2 read ignored");
        run_xfer(1'b1, 2'b11, 4'd8, 0, 1'b1, 0, 1'b0, "R2 read line ignored");
        run_xfer(1'b0, 2'b01, 4'd3, 0, 1'b1, 0, 1'b0, "R2 byte ignored");
        run_xfer(1'b0, 2'b10, 4'd9, 2, 1'b1, 0, 1'b0, "R2 word ignored");
    endtask

    // R2: a start during a burst is not taken as a new transfer
    task automatic t_start_while_busy();
        int acks = 0;
        @(negedge clk);
        start_i = 1'b1; rnw_i = 1'b0; size_i = 2'b11; waddr_i = 4'b0000;
        burst_en_i = 1'b1; wait_cfg_i = 2'd1; data_i = 32'h1111_0000;
        @(negedge clk);
        start_i = 1'b1; size_i = 2'b00; waddr_i = 4'b1101;
        for (int c = 2; c <= 14; c++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (ack_o) acks++;
        end
        for (int j = 0; j < 4; j++) model[j] = 32'h1111_0000;
        check(acks == 4, "R2 start while busy beat count", acks, 4);
        check_mem("R2 start while busy memory");
    endtask

    initial begin
        #(HALF * 2 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_long();
        t_burst();
        t_refused();
        t_ignored();
        t_start_while_busy();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule